// File: doc/BRIEF.md
# Misaligned Unit-Stride Vector Load Aligner

This block sits between a 128-bit memory read bus and the write port of an eight-lane vector register file. A unit-stride vector load starts at any byte address, with elements of 8, 16 or 32 bits. The block issues one 16-byte-aligned beat address per cycle. It joins pairs of consecutive beats when the start address is misaligned, using a delay register, a byte shifter and a select. Each element goes to its lane with a per-lane write enable and a row number, and is widened to 32 bits by sign or zero extension.

A load begins with a `start` pulse while the block is idle. The block captures the base, increment, length, element size and extension mode, then runs on its own. Memory returns each beat one cycle after its request. A misaligned start costs exactly one extra fetch and one extra cycle. Byte loads move eight elements per cycle and use the bus every other cycle. Halfword loads move eight per cycle. Word loads move four per cycle, one half of the lanes at a time. At the end, `done` pulses and `base_out` takes the base plus the scalar increment. This update happens even for a zero-length load.

Top module: `vload_aligner`

## Requirements
- R1: Every request drives `mem_addr` with its low four bits zero. The first request of a load is at the start address rounded down to 16 bytes. Each later request is 16 bytes above the previous one.
- R2: A load of L>0 elements of B bytes issues ceil(L*B/16) requests when the start address is 16-byte aligned, and exactly one more when it is not. A load with L=0 issues none.
- R3: `esize` selects the element size: 0 is byte, 1 is halfword, 2 or 3 is word. Element e is built from memory bytes start+e*B upward, little-endian. It is written exactly once, in lane e mod 8, with `wr_row` = e/8. Lane l data is `wr_data[32*l+31:32*l]`.
- R4: With `sext`=1, byte and halfword elements are sign-extended to 32 bits. With `sext`=0 they are zero-extended.
- R5: No lane is enabled for an element index at or beyond the vector length.
- R6: Count cycles from t=0, the cycle after `start` is accepted. With W writes (ceil(L/4) for words, ceil(L/8) otherwise) and m=1 for a misaligned start, `done` is high in cycle W+2+m.
- R7: `done` is a single-cycle pulse and `busy` is low while it is high. A zero-length load raises `done` in cycle t=0 and makes no request. An idle block makes no request and enables no lane.
- R8: `base_out` changes only when `done` is high, and then becomes start address plus `incr`. This also holds for zero-length loads.
- R9: `start` and the other request inputs are ignored while `busy` is high. The running load's data, timing and final base are unchanged.
- R10: After reset `busy`, `mem_req`, `wr_en` and `done` are low and `base_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load; accepted only while idle |
| base_addr | input | ADDR_W | Byte start address of the load |
| incr | input | ADDR_W | Scalar post-increment for the base |
| vlen | input | VL_W | Number of elements, 0 to MAX_VL |
| esize | input | 2 | Element size: 0 byte, 1 halfword, 2/3 word |
| sext | input | 1 | 1 sign-extends, 0 zero-extends |
| busy | output | 1 | A load is in progress |
| mem_req | output | 1 | Beat request this cycle |
| mem_addr | output | ADDR_W | 16-byte-aligned beat address |
| mem_rdata | input | 128 | Beat data, valid the cycle after its request |
| wr_en | output | 8 | Per-lane write enable |
| wr_row | output | ROW_W | Element row (element index / 8) |
| wr_data | output | 256 | Eight 32-bit lane values |
| done | output | 1 | Pulse after the last lane write |
| base_out | output | ADDR_W | Post-incremented base address |

## Verification
The assertions assume memory answers every request with data exactly one cycle later. They also assume `vlen` never exceeds MAX_VL. The bench's memory model registers the beat for each request on the same edge that sees it. It only ever applies lengths up to 32. The stride property also relies on no new load being accepted in the cycle a request is made. The stimulus meets this because requests only occur while `busy` is high, and a start is only taken while it is low. Start offsets sweep all sixteen byte positions for all three sizes and both extension modes. Some runs pulse `start` with different inputs in mid-load.

// File: rtl/vload_aligner.sv
`timescale 1ns/1ps
module vload_aligner #(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 32,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int ROW_W = $clog2(MAX_VL / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] incr,
  input  logic [VL_W-1:0]   vlen,
  input  logic [1:0]        esize,
  input  logic              sext,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [127:0]      mem_rdata,
  output logic [7:0]        wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [255:0]      wr_data,
  output logic              done,
  output logic [ADDR_W-1:0] base_out
);
  localparam int CNT_W = $clog2(MAX_VL / 4 + 2);
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;

  logic [1:0]        sz;
  logic              sx, first, ph, req_q, chunk_v, half;
  logic [VL_W-1:0]   vl, nwr, wcnt;
  logic [3:0]        off;
  logic [ADDR_W-1:0] abase, base_q, incr_q;
  logic [CNT_W-1:0]  nbeats, fidx, arr_cnt;
  logic [127:0]      dly, chunk_q;

  wire mis    = off != 4'd0;
  wire accept = start & ~busy;

  wire [1:0]      sz_in     = esize[1] ? SZ_W : esize;
  wire [VL_W+1:0] bytes_in  = {2'b00, vlen} << sz_in;
  wire [VL_W+1:0] chunks_in = (bytes_in + (VL_W+2)'(15)) >> 4;
  wire [CNT_W-1:0] nbeats_in = (vlen == '0) ? '0 :
                               CNT_W'(chunks_in) + CNT_W'(base_addr[3:0] != 4'd0);
  wire [VL_W-1:0] nwr_in = (sz_in == SZ_W) ? (vlen + VL_W'(3)) >> 2
                                           : (vlen + VL_W'(7)) >> 3;

  wire pace = (sz != SZ_B) | (mis ? (first | ph) : ~ph);
  assign mem_req  = busy & (fidx < nbeats) & pace;
  assign mem_addr = abase + ADDR_W'({fidx, 4'b0000});

  wire [255:0] win   = {mem_rdata, dly};
  wire [127:0] asm_d = mis ? 128'(win >> {off, 3'b000}) : mem_rdata;
  wire         asm_v = req_q & (~mis | (arr_cnt != '0));

  wire wr_act  = chunk_v;
  wire wr_last = wr_act & (wcnt == nwr - VL_W'(1));
  assign wr_row = (sz == SZ_W) ? wcnt[ROW_W:1] : wcnt[ROW_W-1:0];

  for (genvar l = 0; l < 8; l++) begin : g_lane
    int          e;
    logic [31:0] val;
    logic        hit;
    always_comb begin
      case (sz)
        SZ_B: begin
          e   = int'(wcnt) * 8 + l;
          val = {{24{sx & chunk_q[{half, 3'(l), 3'b111}]}}, chunk_q[{half, 3'(l), 3'b000} +: 8]};
          hit = 1'b1;
        end
        SZ_H: begin
          e   = int'(wcnt) * 8 + l;
          val = {{16{sx & chunk_q[16*l+15]}}, chunk_q[16*l +: 16]};
          hit = 1'b1;
        end
        default: begin
          e   = int'(wcnt) * 4 + (l % 4);
          val = chunk_q[32*(l%4) +: 32];
          hit = ((l / 4) == 0) ? ~wcnt[0] : wcnt[0];
        end
      endcase
    end
    assign wr_en[l] = wr_act & hit & (e < int'(vl));
    assign wr_data[32*l +: 32] = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; req_q <= 1'b0; chunk_v <= 1'b0; half <= 1'b0;
      first <= 1'b0; ph <= 1'b0; sz <= SZ_B; sx <= 1'b0; vl <= '0; nwr <= '0;
      wcnt <= '0; off <= '0; abase <= '0; base_q <= '0; incr_q <= '0;
      nbeats <= '0; fidx <= '0; arr_cnt <= '0; dly <= '0; chunk_q <= '0;
      base_out <= '0;
    end else begin
      done  <= 1'b0;
      req_q <= mem_req;
      if (accept) begin
        sz <= sz_in; sx <= sext; vl <= vlen; off <= base_addr[3:0];
        abase <= {base_addr[ADDR_W-1:4], 4'b0000};
        base_q <= base_addr; incr_q <= incr;
        nbeats <= nbeats_in; nwr <= nwr_in;
        fidx <= '0; arr_cnt <= '0; wcnt <= '0;
        first <= 1'b1; ph <= 1'b0; chunk_v <= 1'b0; half <= 1'b0;
        busy <= vlen != '0;
        if (vlen == '0) begin
          done <= 1'b1;
          base_out <= base_addr + incr;
        end
      end else if (busy) begin
        first <= 1'b0;
        ph    <= ~ph;
        if (mem_req) fidx <= fidx + CNT_W'(1);
        if (req_q) begin
          dly <= mem_rdata;
          arr_cnt <= arr_cnt + CNT_W'(1);
        end
        if (asm_v) begin
          chunk_q <= asm_d; chunk_v <= 1'b1; half <= 1'b0;
        end else if (wr_act) begin
          half <= ~half;
          if (sz != SZ_B || half) chunk_v <= 1'b0;
        end
        if (wr_act) wcnt <= wcnt + VL_W'(1);
        if (wr_last) begin
          busy <= 1'b0; done <= 1'b1; chunk_v <= 1'b0;
          base_out <= base_q + incr_q;
        end
      end
    end
  end
endmodule

// File: rtl/vload_aligner_chk.sv
`timescale 1ns/1ps
module vload_aligner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        wr_en,
  input logic              done,
  input logic [ADDR_W-1:0] base_out
);
  assert_req_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[3:0] == 4'd0);

  assert_req_stride_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && busy && $past(busy)) |-> mem_addr == $past(mem_addr) + ADDR_W'(16));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && wr_en == 8'd0));

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start)));

  assert_base_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(base_out));
endmodule

bind vload_aligner vload_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_req(mem_req),
  .mem_addr(mem_addr), .wr_en(wr_en), .done(done), .base_out(base_out)
);

// File: tb/vload_aligner_bench.sv
`timescale 1ns/1ps
module vload_aligner_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  base_addr = '0, incr = '0;
  logic [5:0]   vlen = '0;
  logic [1:0]   esize = '0;
  logic         sext = 1'b0;
  logic         busy, mem_req, done;
  logic [31:0]  mem_addr, base_out;
  logic [127:0] mem_rdata = '0;
  logic [7:0]   wr_en;
  logic [1:0]   wr_row;
  logic [255:0] wr_data;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vload_aligner u_vload_aligner (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .incr(incr),
    .vlen(vlen), .esize(esize), .sext(sext), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .done(done), .base_out(base_out)
  );

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    logic [31:0] v = a * 32'd29 + (a >> 4) * 32'd3 + 32'h85;
    return v[7:0];
  endfunction

  always @(posedge clk)
    if (mem_req)
      for (int i = 0; i < 16; i++)
        mem_rdata[8*i +: 8] <= mbyte({mem_addr[31:4], 4'b0000} + 32'(i));

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [31:0] expect_elem(input logic [31:0] b, input int e, input int s, input bit sx);
    int nb = 1 << s;
    logic [31:0] raw = '0;
    for (int i = 0; i < nb; i++) raw[8*i +: 8] = mbyte(b + 32'(e * nb + i));
    if (s == 0) return sx ? {{24{raw[7]}}, raw[7:0]} : {24'd0, raw[7:0]};
    if (s == 1) return sx ? {{16{raw[15]}}, raw[15:0]} : {16'd0, raw[15:0]};
    return raw;
  endfunction

  task automatic run(input logic [31:0] b, input logic [31:0] inc, input int vl,
                     input int s, input bit sx, input bit poke);
    logic [31:0] got [32];
    int cnt [32];
    int nb = 1 << s;
    int mis = (b[3:0] != 4'd0) ? 1 : 0;
    int w = (s == 2) ? (vl + 3) / 4 : (vl + 7) / 8;
    int exp_k = (vl == 0) ? 0 : w + 2 + mis;
    int exp_beats = (vl == 0) ? 0 : (vl * nb + 15) / 16 + mis;
    int nbeat = 0, done_k = -1, stray = 0, bad_addr = 0, bad_data = 0, bad_cnt = 0;
    logic [31:0] next_a = {b[31:4], 4'b0000};
    logic [31:0] bad_got = '0, bad_exp = '0;
    for (int e = 0; e < 32; e++) begin cnt[e] = 0; got[e] = '0; end

    @(negedge clk);
    base_addr = b; incr = inc; vlen = 6'(vl); esize = 2'(s); sext = sx; start = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (poke && k == 1) begin
        start = 1'b1; base_addr = ~b; incr = 32'h55; vlen = 6'd3; esize = 2'd0; sext = ~sx;
      end
      if (poke && k == 2) start = 1'b0;
      if (mem_req) begin
        nbeat++;
        if (mem_addr != next_a) bad_addr++;
        next_a = mem_addr + 32'd16;
      end
      for (int l = 0; l < 8; l++)
        if (wr_en[l]) begin
          int e = int'(wr_row) * 8 + l;
          if (e >= vl) stray++;
          else begin cnt[e]++; got[e] = wr_data[32*l +: 32]; end
        end
      if (done) begin done_k = k; break; end
    end

    for (int e = 0; e < vl; e++) begin
      logic [31:0] x = expect_elem(b, e, s, sx);
      if (cnt[e] != 1) bad_cnt++;
      if (got[e] != x && bad_data == 0) begin bad_got = got[e]; bad_exp = x; end
      if (got[e] != x) bad_data++;
    end

    check(bad_addr == 0, $sformatf("R1 address sequence: %0d bad addresses, expected 0 (b=%h s=%0d vl=%0d)", bad_addr, b, s, vl));
    check(nbeat == exp_beats, $sformatf("R2 beat count: got %0d expected %0d (b=%h s=%0d vl=%0d)", nbeat, exp_beats, b, s, vl));
    check(bad_data == 0 && bad_cnt == 0,
      $sformatf("%s element data: %0d wrong, %0d not written once, first got %h expected %h (b=%h s=%0d vl=%0d)",
                sx ? "R4" : "R3", bad_data, bad_cnt, bad_got, bad_exp, b, s, vl));
    check(stray == 0, $sformatf("R5 writes beyond length: got %0d expected 0 (s=%0d vl=%0d)", stray, s, vl));
    check(done_k == exp_k, $sformatf("R6 done cycle: got %0d expected %0d (b=%h s=%0d vl=%0d)", done_k, exp_k, b, s, vl));
    if (poke)
      check(bad_data == 0 && done_k == exp_k,
        $sformatf("R9 start while busy disturbed load: data errors %0d done %0d, expected 0 and %0d", bad_data, done_k, exp_k));
    base_addr = b; incr = inc;
    @(negedge clk);
    check(!done && !busy && !mem_req && wr_en == 8'd0,
      $sformatf("R7 after done: done=%b busy=%b req=%b en=%h expected all zero", done, busy, mem_req, wr_en));
    check(base_out == b + inc, $sformatf("R8 base_out: got %h expected %h", base_out, b + inc));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R6 watchdog: run still active after 190000 cycles, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lens [8] = '{0, 1, 5, 8, 13, 16, 31, 32};
    int n = 0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && wr_en == 8'd0 && !done && base_out == 32'd0,
      $sformatf("R10 reset state: busy=%b req=%b en=%h done=%b base=%h expected all zero", busy, mem_req, wr_en, done, base_out));
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req && !done, $sformatf("R10 idle after reset: busy=%b req=%b done=%b expected 0", busy, mem_req, done));
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 16; o++)
        for (int li = 0; li < 8; li++)
          for (int sx = 0; sx < 2; sx++) begin
            logic [31:0] b = 32'h1000_0000 + 32'(n * 48) * 32'd16 + 32'(o);
            logic [31:0] inc = 32'(n * 37 + 4) ^ 32'hF000_0000;
            run(b, inc, lens[li], s, sx[0], (o % 5) == 1);
            n++;
          end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule